// File: doc/BRIEF.md
# Multiply-Subtract Accumulator

This block is a two-stage multiply-subtract datapath built around a 32-bit accumulator. Each accepted command multiplies two register operands, either as 16-bit halves or as full 32-bit words, signed or unsigned. It then scales the product by one bit to the left, one bit to the right, or not at all, and subtracts the scaled product from the accumulator. A sticky flag records any overflow of that subtraction in the signedness the command chose.

When the `HAS_LOAD` parameter is set, one opcode also runs a load path next to the accumulate. A data word fetched elsewhere comes in with the command and can be ANDed with a mask value. The result leaves on a write-back port, tagged with a destination register index, in the same cycle as the accumulator update. Two further opcodes preset the accumulator and clear the overflow flag. Both travel through the same pipeline, so every effect lands in command order.

Top module: `msac_unit`

## Requirements
- R1: After reset, `acc_value` is 0, `ovf_flag` is 0 and `wb_valid` is 0.
- R2: Opcode 2'b11 loads `cmd_x` into the accumulator without touching `ovf_flag`. Every command accepted on a rising edge k shows its effect on the outputs after rising edge k+1.
- R3: Opcodes 2'b00 and 2'b01 replace the accumulator with accumulator minus scaled product. `cmd_ready` is always 1, so one command is accepted on every cycle in which `cmd_valid` is 1.
- R4: With `cmd_long`=0 each operand is a 16-bit half of its 32-bit input. The half is bits 31:16 when its select (`cmd_x_hi`, `cmd_y_hi`) is 1, and bits 15:0 otherwise. The half is sign-extended when `cmd_signed`=1 and zero-extended when it is 0.
- R5: With `cmd_long`=1 the full 32-bit operands are multiplied, and only the low 32 bits of the product are used.
- R6: `cmd_scale` 2'b00 leaves the product unshifted, and 2'b10 does the same. 2'b01 shifts it left by one bit, keeping 32 bits. 2'b11 shifts it right by one bit, arithmetically when `cmd_signed`=1 and logically otherwise.
- R7: `ovf_flag` sets when a multiply-subtract result leaves the 32-bit range. The range is two's complement for signed commands; for unsigned commands the flag sets on a borrow. Once set, the flag stays set through later commands.
- R8: Opcode 2'b10 clears `ovf_flag` with the same latency as R2 and leaves the accumulator unchanged.
- R9: Opcode 2'b01 also pulses `wb_valid` for one cycle, in the same cycle its accumulator result appears. `wb_idx` equals `cmd_dest`. `wb_data` equals `cmd_ldata`, or `cmd_ldata & mask_value` when `cmd_mask_en`=1, with `mask_value` sampled when the command is accepted.
- R10: Back-to-back load commands to the same register give write-back pulses in issue order, so the later command's data is the last one written.
- R11: While `cmd_valid` is 0, the accumulator, the flag and the write-back port do not change, whatever the other command inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (always 1) |
| cmd_op | input | 2 | 00 multiply-subtract, 01 multiply-subtract with load, 10 clear flag, 11 preset accumulator |
| cmd_x | input | ACC_W | First operand, or preset value |
| cmd_y | input | ACC_W | Second operand |
| cmd_long | input | 1 | 1: full-width operands, 0: half-width operands |
| cmd_x_hi | input | 1 | Upper-half select for cmd_x |
| cmd_y_hi | input | 1 | Upper-half select for cmd_y |
| cmd_signed | input | 1 | Signed multiply and overflow sense |
| cmd_scale | input | 2 | Product scale code |
| cmd_mask_en | input | 1 | AND the load word with mask_value |
| cmd_dest | input | IDX_W | Write-back register index |
| cmd_ldata | input | ACC_W | Fetched load word |
| mask_value | input | ACC_W | Mask register contents |
| acc_value | output | ACC_W | Accumulator |
| ovf_flag | output | 1 | Sticky overflow flag |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | IDX_W | Write-back register index |
| wb_data | output | ACC_W | Write-back data |

## Verification
The bound assertions watch the timing on every cycle. A write-back pulse comes exactly two cycles after each load command, and its index and data match the masked or unmasked word that command carried. The flag falls only two cycles after a clear and rises only two cycles after a multiply-subtract. The accumulator moves only two cycles after a command that is not a clear. The arithmetic itself can only be shown by the bench's scenarios, which compare against an independent model. These cover half selection, sign and zero extension, truncation of full-width products, each scale code, the boundaries where signed and unsigned overflow set the flag, and ordering of write-backs to the same register.

// File: rtl/msac_pkg.sv
`timescale 1ns/1ps
package msac_pkg;
   typedef enum logic [1:0] {
      OP_MSAC    = 2'b00,
      OP_MSAC_LD = 2'b01,
      OP_CLR_OVF = 2'b10,
      OP_ACC_SET = 2'b11
   } msac_op_e;

   typedef enum logic [1:0] {
      SC_NONE  = 2'b00,
      SC_LEFT  = 2'b01,
      SC_RSVD  = 2'b10,
      SC_RIGHT = 2'b11
   } msac_scale_e;
endpackage

// File: rtl/msac_mult.sv
`timescale 1ns/1ps
module msac_mult #(
   parameter int ACC_W = 32
) (
   input  logic [ACC_W-1:0] op_x,
   input  logic [ACC_W-1:0] op_y,
   input  logic             use_long,
   input  logic             x_hi,
   input  logic             y_hi,
   input  logic             is_signed,
   output logic [ACC_W-1:0] prod
);
   localparam int HALF_W = ACC_W / 2;

   logic [HALF_W-1:0] half_x, half_y;
   logic [ACC_W-1:0]  ext_x, ext_y, fac_x, fac_y;

   always_comb begin
      half_x = x_hi ? op_x[ACC_W-1:HALF_W] : op_x[HALF_W-1:0];
      half_y = y_hi ? op_y[ACC_W-1:HALF_W] : op_y[HALF_W-1:0];
      ext_x  = {{HALF_W{is_signed & half_x[HALF_W-1]}}, half_x};
      ext_y  = {{HALF_W{is_signed & half_y[HALF_W-1]}}, half_y};
      fac_x  = use_long ? op_x : ext_x;
      fac_y  = use_long ? op_y : ext_y;
      prod   = fac_x * fac_y;
   end
endmodule

// File: rtl/msac_accum.sv
`timescale 1ns/1ps
module msac_accum
   import msac_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s1_valid,
   input  msac_op_e         s1_op,
   input  logic [ACC_W-1:0] s1_word,
   input  msac_scale_e      s1_scale,
   input  logic             s1_signed,
   output logic [ACC_W-1:0] acc,
   output logic             ovf
);
   localparam int MSB = ACC_W - 1;

   logic [ACC_W-1:0] scaled, diff;
   logic             ovf_now;

   always_comb begin
      unique case (s1_scale)
         SC_LEFT:  scaled = {s1_word[MSB-1:0], 1'b0};
         SC_RIGHT: scaled = {s1_signed & s1_word[MSB], s1_word[MSB:1]};
         default:  scaled = s1_word;
      endcase
      diff = acc - scaled;
      if (s1_signed)
         ovf_now = (acc[MSB] != scaled[MSB]) && (diff[MSB] != acc[MSB]);
      else
         ovf_now = acc < scaled;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         ovf <= 1'b0;
      end else if (s1_valid) begin
         unique case (s1_op)
            OP_MSAC, OP_MSAC_LD: begin
               acc <= diff;
               ovf <= ovf | ovf_now;
            end
            OP_CLR_OVF: ovf <= 1'b0;
            OP_ACC_SET: acc <= s1_word;
         endcase
      end
   end
endmodule

// File: rtl/msac_loadpath.sv
`timescale 1ns/1ps
module msac_loadpath #(
   parameter int ACC_W = 32,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_fire,
   input  logic [ACC_W-1:0] ld_word,
   input  logic [ACC_W-1:0] ld_mask,
   input  logic             ld_mask_en,
   input  logic [IDX_W-1:0] ld_dest,
   output logic             wb_valid,
   output logic [IDX_W-1:0] wb_idx,
   output logic [ACC_W-1:0] wb_data
);
   logic             p_valid;
   logic [IDX_W-1:0] p_idx;
   logic [ACC_W-1:0] p_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_valid  <= 1'b0;
         p_idx    <= '0;
         p_data   <= '0;
         wb_valid <= 1'b0;
         wb_idx   <= '0;
         wb_data  <= '0;
      end else begin
         p_valid  <= ld_fire;
         if (ld_fire) begin
            p_idx  <= ld_dest;
            p_data <= ld_mask_en ? (ld_word & ld_mask) : ld_word;
         end
         wb_valid <= p_valid;
         if (p_valid) begin
            wb_idx  <= p_idx;
            wb_data <= p_data;
         end
      end
   end
endmodule

// File: rtl/msac_unit.sv
`timescale 1ns/1ps
module msac_unit
   import msac_pkg::*;
#(
   parameter int ACC_W    = 32,
   parameter int IDX_W    = 4,
   parameter bit HAS_LOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [1:0]       cmd_op,
   input  logic [ACC_W-1:0] cmd_x,
   input  logic [ACC_W-1:0] cmd_y,
   input  logic             cmd_long,
   input  logic             cmd_x_hi,
   input  logic             cmd_y_hi,
   input  logic             cmd_signed,
   input  logic [1:0]       cmd_scale,
   input  logic             cmd_mask_en,
   input  logic [IDX_W-1:0] cmd_dest,
   input  logic [ACC_W-1:0] cmd_ldata,
   input  logic [ACC_W-1:0] mask_value,
   output logic [ACC_W-1:0] acc_value,
   output logic             ovf_flag,
   output logic             wb_valid,
   output logic [IDX_W-1:0] wb_idx,
   output logic [ACC_W-1:0] wb_data
);
   if (ACC_W < 8 || (ACC_W % 2) != 0) begin : g_bad_acc_w
      $error("msac_unit: ACC_W must be even and at least 8");
   end
   if (IDX_W < 1) begin : g_bad_idx_w
      $error("msac_unit: IDX_W must be at least 1");
   end

   logic             fire;
   logic [ACC_W-1:0] prod;
   logic             s1_valid;
   msac_op_e         s1_op;
   logic [ACC_W-1:0] s1_word;
   msac_scale_e      s1_scale;
   logic             s1_signed;

   assign cmd_ready = 1'b1;
   assign fire      = cmd_valid & cmd_ready;

   msac_mult #(.ACC_W(ACC_W)) u_mult (
      .op_x(cmd_x), .op_y(cmd_y), .use_long(cmd_long),
      .x_hi(cmd_x_hi), .y_hi(cmd_y_hi), .is_signed(cmd_signed),
      .prod(prod)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_op     <= OP_MSAC;
         s1_word   <= '0;
         s1_scale  <= SC_NONE;
         s1_signed <= 1'b0;
      end else begin
         s1_valid <= fire;
         if (fire) begin
            s1_op     <= msac_op_e'(cmd_op);
            s1_word   <= (msac_op_e'(cmd_op) == OP_ACC_SET) ? cmd_x : prod;
            s1_scale  <= msac_scale_e'(cmd_scale);
            s1_signed <= cmd_signed;
         end
      end
   end

   msac_accum #(.ACC_W(ACC_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_op(s1_op),
      .s1_word(s1_word), .s1_scale(s1_scale), .s1_signed(s1_signed),
      .acc(acc_value), .ovf(ovf_flag)
   );

   if (HAS_LOAD) begin : g_load
      msac_loadpath #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_load (
         .clk(clk), .rst_n(rst_n),
         .ld_fire(fire && msac_op_e'(cmd_op) == OP_MSAC_LD),
         .ld_word(cmd_ldata), .ld_mask(mask_value), .ld_mask_en(cmd_mask_en),
         .ld_dest(cmd_dest), .wb_valid(wb_valid), .wb_idx(wb_idx),
         .wb_data(wb_data)
      );
   end else begin : g_no_load
      assign wb_valid = 1'b0;
      assign wb_idx   = '0;
      assign wb_data  = '0;
   end
endmodule

// File: rtl/msac_unit_chk.sv
`timescale 1ns/1ps
module msac_unit_chk #(
   parameter int ACC_W    = 32,
   parameter int IDX_W    = 4,
   parameter bit HAS_LOAD = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [1:0]       cmd_op,
   input logic             cmd_mask_en,
   input logic [IDX_W-1:0] cmd_dest,
   input logic [ACC_W-1:0] cmd_ldata,
   input logic [ACC_W-1:0] mask_value,
   input logic [ACC_W-1:0] acc_value,
   input logic             ovf_flag,
   input logic             wb_valid,
   input logic [IDX_W-1:0] wb_idx,
   input logic [ACC_W-1:0] wb_data
);
   logic fire, ld_fire, clr_fire, msac_fire, moves_acc;
   assign fire      = cmd_valid && cmd_ready;
   assign ld_fire   = fire && cmd_op == 2'b01;
   assign clr_fire  = fire && cmd_op == 2'b10;
   assign msac_fire = fire && !cmd_op[1];
   assign moves_acc = fire && cmd_op != 2'b10;

   // R9
   ld_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_LOAD && ld_fire) |=> ##1 wb_valid);
   // R9
   wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ($past(ld_fire, 2) && wb_idx == $past(cmd_dest, 2)));
   // R9
   wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_data == ($past(cmd_mask_en, 2)
                                ? ($past(cmd_ldata, 2) & $past(mask_value, 2))
                                : $past(cmd_ldata, 2))));
   // R8
   ovf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag) |-> $past(clr_fire, 2));
   // R7
   ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(msac_fire, 2));
   // R3
   acc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc_value) |-> $past(moves_acc, 2));
endmodule

bind msac_unit msac_unit_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W), .HAS_LOAD(HAS_LOAD)) u_chk (.*);

// File: tb/tb_msac_unit.sv
`timescale 1ns/1ps
module tb_msac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'b00;
   logic [31:0] cmd_x = '0, cmd_y = '0, cmd_ldata = '0, mask_value = '0;
   logic        cmd_long = 1'b0, cmd_x_hi = 1'b0, cmd_y_hi = 1'b0, cmd_signed = 1'b0;
   logic [1:0]  cmd_scale = 2'b00;
   logic        cmd_mask_en = 1'b0;
   logic [3:0]  cmd_dest = '0;
   logic [31:0] acc_value, wb_data;
   logic        ovf_flag, wb_valid;
   logic [3:0]  wb_idx;

   always #5 clk = ~clk;

   msac_unit dut (.*);

   typedef struct {
      logic [31:0] acc;
      logic        ovf;
      logic        wv;
      logic [3:0]  wi;
      logic [31:0] wd;
      string       tag;
   } exp_t;

   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   exp_t e1, e2;
   logic [31:0] m_acc = '0;
   logic        m_ovf = 1'b0;

   function automatic logic [31:0] ref_prod(logic [31:0] x, logic [31:0] y, logic lng,
                                            logic xh, logic yh, logic sg);
      longint a, b, p;
      logic [15:0] hx, hy;
      hx = xh ? x[31:16] : x[15:0];
      hy = yh ? y[31:16] : y[15:0];
      if (lng) begin
         a = sg ? longint'(signed'(x)) : longint'(x);
         b = sg ? longint'(signed'(y)) : longint'(y);
      end else begin
         a = sg ? longint'(signed'(hx)) : longint'(hx);
         b = sg ? longint'(signed'(hy)) : longint'(hy);
      end
      p = a * b;
      return p[31:0];
   endfunction

   function automatic logic [31:0] ref_scale(logic [31:0] p, logic [1:0] sc, logic sg);
      longint v;
      if (sc == 2'b01) return p << 1;
      if (sc == 2'b11) begin
         v = sg ? (longint'(signed'(p)) >>> 1) : (longint'(p) >> 1);
         return v[31:0];
      end
      return p;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic check_outputs();
      chk(e2.tag, "acc_value", acc_value, e2.acc);
      chk(e2.tag, "ovf_flag", {31'b0, ovf_flag}, {31'b0, e2.ovf});
      chk(e2.wv ? "R9" : e2.tag, "wb_valid", {31'b0, wb_valid}, {31'b0, e2.wv});
      if (e2.wv) begin
         chk("R9", "wb_idx", {28'b0, wb_idx}, {28'b0, e2.wi});
         chk(e2.tag, "wb_data", wb_data, e2.wd);
      end
   endtask

   // one cycle: check outputs due now, then drive a command (or idle)
   task automatic step(string tag, logic v, logic [1:0] op, logic [31:0] x, logic [31:0] y,
                       logic lng, logic xh, logic yh, logic sg, logic [1:0] sc,
                       logic men, logic [3:0] dst, logic [31:0] ld, logic [31:0] msk);
      logic [31:0] sp;
      longint      d;
      @(negedge clk);
      check_outputs();
      e2 = e1;
      cmd_valid = v; cmd_op = op; cmd_x = x; cmd_y = y; cmd_long = lng;
      cmd_x_hi = xh; cmd_y_hi = yh; cmd_signed = sg; cmd_scale = sc;
      cmd_mask_en = men; cmd_dest = dst; cmd_ldata = ld; mask_value = msk;
      e1.wv = 1'b0; e1.wi = '0; e1.wd = '0; e1.tag = tag;
      if (v) begin
         case (op)
            2'b00, 2'b01: begin
               sp = ref_scale(ref_prod(x, y, lng, xh, yh, sg), sc, sg);
               if (sg) begin
                  d = longint'(signed'(m_acc)) - longint'(signed'(sp));
                  if (d > 64'sd2147483647 || d < -64'sd2147483648) m_ovf = 1'b1;
               end else begin
                  d = longint'(m_acc) - longint'(sp);
                  if (d < 0) m_ovf = 1'b1;
               end
               m_acc = d[31:0];
               if (op == 2'b01) begin
                  e1.wv = 1'b1; e1.wi = dst; e1.wd = men ? (ld & msk) : ld;
               end
            end
            2'b10: m_ovf = 1'b0;
            default: m_acc = x;
         endcase
      end
      e1.acc = m_acc; e1.ovf = m_ovf;
   endtask

   task automatic ms(string tag, logic [31:0] x, logic [31:0] y, logic lng, logic xh,
                     logic yh, logic sg, logic [1:0] sc);
      step(tag, 1'b1, 2'b00, x, y, lng, xh, yh, sg, sc, 1'b0, 4'd0, 32'h0, 32'h0);
   endtask

   task automatic setacc(string tag, logic [31:0] x);
      step(tag, 1'b1, 2'b11, x, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd0, 32'h0, 32'h0);
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++)
         step(tag, 1'b0, 2'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 4'($urandom),
              $urandom, $urandom);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      e1 = '{acc: 32'h0, ovf: 1'b0, wv: 1'b0, wi: 4'h0, wd: 32'h0, tag: "R1"};
      e2 = e1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "acc_value", acc_value, 32'h0);
      chk("R1", "ovf_flag", {31'b0, ovf_flag}, 32'h0);
      chk("R1", "wb_valid", {31'b0, wb_valid}, 32'h0);
      chk("R3", "cmd_ready", {31'b0, cmd_ready}, 32'h1);
      rst_n = 1'b1;

      setacc("R2", 32'd100);
      ms("R4", 32'd3, 32'h0000_FFFE, 0, 0, 0, 1, 2'b00);           // 100 - (-6)
      ms("R4", 32'h0005_0000, 32'h0007_1234, 0, 1, 1, 1, 2'b00);    // upper halves
      ms("R4", 32'd2, 32'h0000_FFFF, 0, 0, 0, 0, 2'b00);            // zero-extended
      ms("R4", 32'hFFFF_0002, 32'h0003_8000, 0, 1, 0, 1, 2'b00);    // -1 * -32768
      ms("R5", 32'h0001_0000, 32'h0001_0001, 1, 0, 0, 0, 2'b00);    // truncated
      ms("R5", 32'hFFFF_FFFD, 32'h0000_0007, 1, 0, 0, 1, 2'b00);
      ms("R6", 32'd5, 32'd3, 0, 0, 0, 1, 2'b01);
      ms("R6", 32'hFFFF_FFF9, 32'd1, 1, 0, 0, 1, 2'b11);            // arithmetic right
      ms("R6", 32'hFFFF_FFF9, 32'd1, 1, 0, 0, 0, 2'b11);            // logical right
      ms("R6", 32'd9, 32'd9, 0, 0, 0, 0, 2'b10);                    // reserved code
      idle("R11", 3);

      setacc("R7", 32'h8000_0001);
      ms("R7", 32'd1, 32'd1, 1, 0, 0, 1, 2'b00);                    // reaches min, no ovf
      ms("R7", 32'd1, 32'd1, 1, 0, 0, 1, 2'b00);                    // signed overflow
      ms("R7", 32'd0, 32'd0, 1, 0, 0, 1, 2'b00);                    // stays sticky
      step("R8", 1'b1, 2'b10, 32'hDEAD_BEEF, 32'h0, 0, 0, 0, 0, 2'b00, 0, 4'd0, 32'h0, 32'h0);
      setacc("R7", 32'd0);
      ms("R7", 32'd0, 32'd0, 1, 0, 0, 0, 2'b00);                    // equal, no borrow
      ms("R7", 32'd1, 32'd1, 1, 0, 0, 0, 2'b00);                    // unsigned borrow
      step("R8", 1'b1, 2'b10, 32'h0, 32'h0, 0, 0, 0, 0, 2'b00, 0, 4'd0, 32'h0, 32'h0);
      idle("R11", 2);

      step("R9", 1'b1, 2'b01, 32'd2, 32'd3, 0, 0, 0, 0, 2'b00, 1'b0, 4'd5, 32'hA5A5_1234, 32'h0000_FFFF);
      step("R9", 1'b1, 2'b01, 32'd1, 32'd1, 0, 0, 0, 1, 2'b00, 1'b1, 4'd6, 32'hA5A5_1234, 32'h0000_FFFF);
      step("R10", 1'b1, 2'b01, 32'd1, 32'd0, 0, 0, 0, 0, 2'b00, 1'b0, 4'd9, 32'h1111_1111, 32'h0);
      step("R10", 1'b1, 2'b01, 32'd1, 32'd0, 0, 0, 0, 0, 2'b00, 1'b1, 4'd9, 32'h2222_2222, 32'hFF00_FF00);
      idle("R11", 4);

      for (int i = 0; i < 400; i++) begin
         logic [1:0] op;
         op = 2'($urandom);
         if (op == 2'b10 && ($urandom % 4) != 0) op = 2'b00;
         step("R3", 1'(($urandom % 5) != 0), op, $urandom, $urandom, 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
              4'($urandom), $urandom, $urandom);
      end
      idle("R11", 3);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule